// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block lets a host processor reach a bank of 8-bit configuration registers through a narrow window of eight locations selected by a 3-bit address. The host never addresses a configuration register directly. It first loads an index with the 16-bit number of the target register, then writes or reads a data location to finish the access. The index is held until the host rewrites it, so repeated accesses to one register need only the data step.

Two host bus widths are supported, selected by a mode input. On an 8-bit bus the index is loaded as two bytes through two window locations. On a 16-bit bus it is loaded in one write. In 16-bit mode, bit 14 of the index flags a paired write: one data write then fills two neighbouring registers, one from each half of the data word. Window locations 3 through 7 belong to neighbouring status, interrupt and command logic and are not served here. They read as zero, and writes to them are dropped.

Top module: `cfg_window_port`

## Requirements
- R1: After synchronous reset, `rdata` is 0, the index is 0 and every configuration register reads 0.
- R2: With `bus16_mode`=0, a write to window 0 loads index bits 7:0 from `wdata[7:0]` and a write to window 1 loads index bits 15:8 from `wdata[7:0]`. In both cases the other byte is kept. A read of window 0 or 1 returns that byte in `rdata[7:0]` with `rdata[15:8]`=0.
- R3: With `bus16_mode`=1, a write to window 0 loads all 16 index bits from `wdata`, a write to window 1 leaves the index unchanged, a read of window 0 returns the full index, and a read of window 1 returns 0.
- R4: A write to window 2 stores `wdata[7:0]` into the register whose number is the index with bit 14 forced to 0.
- R5: A read of window 2 puts that register in `rdata[7:0]`, with `rdata[15:8]`=0, at the first clock edge after the strobe is sampled. `rdata` then holds until the next read.
- R6: With `bus16_mode`=1 and index bit 14 set, a write to window 2 stores `wdata[7:0]` at the indexed register and `wdata[15:8]` at the indexed register plus one. With `bus16_mode`=0, bit 14 starts no paired write.
- R7: Register numbers at or above `DEPTH` are not implemented. Writes to them change nothing, reads of them return 0, and a paired write whose upper register falls outside stores only the lower byte.
- R8: An access happens only in a cycle where `cs_n`=0. A write happens where `wr_n`=0. A read happens where `rd_n`=0 and `wr_n`=1. When both strobes are low the write is done and `rdata` is unchanged.
- R9: Reads of windows 3 to 7 return 0, and writes to them change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus16_mode | input | 1 | 1 = 16-bit host bus, 0 = 8-bit host bus |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, sampled each clock |
| rd_n | input | 1 | Active-low read strobe, sampled each clock |
| addr | input | 3 | Window location |
| wdata | input | 16 | Write data (8-bit mode uses bits 7:0) |
| rdata | output | 16 | Registered read data |

## Verification
The checker watches several properties on every cycle. It checks that `rdata` is zero after reset, that `rdata` holds while no read is sampled or the chip is deselected, that data-window reads never drive the upper byte, and that reads of windows 3 to 7 return zero. Other behaviours depend on what was written earlier, and only the bench scenarios can show them. These include how the index is built in each bus mode, the masking of bit 14, the two registers reached by a paired write (including a pair that crosses between the even and odd banks), the dropping of out-of-range and upper-window writes, and the clearing of stored values by reset.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int IDX_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    WIN_IDX_LO = 3'd0,
    WIN_IDX_HI = 3'd1,
    WIN_DATA   = 3'd2
  } win_e;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_EVEN = 2'd1,
    RSEL_ODD  = 2'd2,
    RSEL_IDX  = 2'd3
  } rsel_e;
endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
  import cfg_window_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic             we_full,
  input  logic [IDX_W-1:0] wd,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (we_full) begin
      idx <= wd;
    end else begin
      if (we_lo) idx[BYTE_W-1:0]     <= wd[BYTE_W-1:0];
      if (we_hi) idx[IDX_W-1:BYTE_W] <= wd[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_window_pkg::*;
#(
  parameter int DEPTH_H = 128,
  localparam int AW_H = (DEPTH_H > 1) ? $clog2(DEPTH_H) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW_H-1:0]   wa,
  input  logic [BYTE_W-1:0] wd,
  input  logic              re,
  input  logic [AW_H-1:0]   ra,
  output logic [BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] mem [DEPTH_H];
  logic [DEPTH_H-1:0] written;
  logic [BYTE_W-1:0] mem_q;
  logic              written_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) mem_q <= mem[ra];
  end

  // per-entry written flags give the cleared-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      if (we) written[wa] <= 1'b1;
      if (re) written_q   <= written[ra];
    end
  end

  assign q = written_q ? mem_q : '0;
endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
  import cfg_window_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus16_mode,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int AW      = $clog2(DEPTH);
  localparam int DEPTH_H = DEPTH / 2;
  localparam int AW_H    = (DEPTH_H > 1) ? $clog2(DEPTH_H) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

  logic wr_ev, rd_ev;
  assign wr_ev = !cs_n && !wr_n;
  assign rd_ev = !cs_n && !rd_n && wr_n;

  // index register
  logic [IDX_W-1:0] idx;
  logic we_lo, we_hi, we_full;
  assign we_full = wr_ev && bus16_mode  && (addr == WIN_IDX_LO);
  assign we_lo   = wr_ev && !bus16_mode && (addr == WIN_IDX_LO);
  assign we_hi   = wr_ev && !bus16_mode && (addr == WIN_IDX_HI);

  cfg_index_reg u_idx (
    .clk(clk), .rst(rst), .we_lo(we_lo), .we_hi(we_hi),
    .we_full(we_full), .wd(wdata), .idx(idx)
  );

  // effective register numbers
  logic [IDX_W-1:0] ea;
  logic [IDX_W:0]   ea_hi;
  logic             pair, lo_ok, hi_ok;
  assign ea    = {idx[15], 1'b0, idx[13:0]};
  assign ea_hi = {1'b0, ea} + 1'b1;
  assign pair  = bus16_mode && idx[14];
  assign lo_ok = {1'b0, ea} < LIMIT;
  assign hi_ok = pair && (ea_hi < LIMIT);

  logic data_we, lo_we, hi_we;
  assign data_we = wr_ev && (addr == WIN_DATA);
  assign lo_we   = data_we && lo_ok;
  assign hi_we   = data_we && hi_ok;

  logic [AW_H-1:0] lo_half, hi_half;
  assign lo_half = ea[AW-1:1];
  assign hi_half = ea_hi[AW-1:1];

  logic              bk_we [2];
  logic [AW_H-1:0]   bk_wa [2];
  logic [BYTE_W-1:0] bk_wd [2];
  logic [BYTE_W-1:0] bk_q  [2];
  logic              bk_re;

  // bank 0 holds even registers, bank 1 odd; a pair always spans both
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      if (ea[0] == b[0]) begin
        bk_we[b] = lo_we;
        bk_wa[b] = lo_half;
        bk_wd[b] = wdata[7:0];
      end else begin
        bk_we[b] = hi_we;
        bk_wa[b] = hi_half;
        bk_wd[b] = wdata[15:8];
      end
    end
  end

  assign bk_re = rd_ev && (addr == WIN_DATA) && lo_ok;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    cfg_bank #(.DEPTH_H(DEPTH_H)) u_bank (
      .clk(clk), .rst(rst),
      .we(bk_we[g]), .wa(bk_wa[g]), .wd(bk_wd[g]),
      .re(bk_re), .ra(lo_half), .q(bk_q[g])
    );
  end

  // read select and index snapshot, updated only by reads
  rsel_e            sel_q;
  logic [IDX_W-1:0] idx_snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= RSEL_ZERO;
      idx_snap <= '0;
    end else if (rd_ev) begin
      unique case (addr)
        WIN_DATA: sel_q <= !lo_ok ? RSEL_ZERO : (ea[0] ? RSEL_ODD : RSEL_EVEN);
        WIN_IDX_LO: begin
          sel_q    <= RSEL_IDX;
          idx_snap <= bus16_mode ? idx : {8'h00, idx[7:0]};
        end
        WIN_IDX_HI: begin
          sel_q    <= bus16_mode ? RSEL_ZERO : RSEL_IDX;
          idx_snap <= {8'h00, idx[15:8]};
        end
        default: sel_q <= RSEL_ZERO;
      endcase
    end
  end

  always_comb begin
    unique case (sel_q)
      RSEL_EVEN: rdata = {8'h00, bk_q[0]};
      RSEL_ODD:  rdata = {8'h00, bk_q[1]};
      RSEL_IDX:  rdata = idx_snap;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        wr_n,
  input logic        rd_n,
  input logic [2:0]  addr,
  input logic [15:0] rdata
);
  logic rd_seen;
  assign rd_seen = !cs_n && !rd_n && wr_n;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rdata == 16'h0000));

  assert_data_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && addr == 3'd2) |=> (rdata[15:8] == 8'h00));

  assert_hold_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_seen |=> $stable(rdata));

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(rdata));

  assert_upper_window_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && addr >= 3'd3) |=> (rdata == 16'h0000));
endmodule

bind cfg_window_port cfg_window_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
  .addr(addr), .rdata(rdata)
);

// File: tb/sim_cfg_window_port.sv
module sim_cfg_window_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus16_mode = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_port #(.DEPTH(256)) u0 (
    .clk(clk), .rst(rst), .bus16_mode(bus16_mode), .cs_n(cs_n),
    .wr_n(wr_n), .rd_n(rd_n), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // {is_read, mode16, addr[2:0], wdata[15:0], expect[15:0], req[3:0]}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0,1'b0,3'd0,16'h0012,16'h0000,4'd2},  // R2 low index byte
    {1'b0,1'b0,3'd1,16'h0000,16'h0000,4'd2},  // R2 high index byte
    {1'b1,1'b0,3'd0,16'h0000,16'h0012,4'd2},  // R2 read low byte
    {1'b0,1'b0,3'd2,16'h00A5,16'h0000,4'd4},  // R4 reg 0x12 = A5
    {1'b1,1'b0,3'd2,16'h0000,16'h00A5,4'd5},  // R5 read back
    {1'b0,1'b0,3'd1,16'h0040,16'h0000,4'd2},  // R2 index 0x4012
    {1'b1,1'b0,3'd1,16'h0000,16'h0040,4'd2},  // R2 read high byte
    {1'b1,1'b0,3'd0,16'h0000,16'h0012,4'd2},  // R2 low byte kept
    {1'b0,1'b0,3'd2,16'hBB77,16'h0000,4'd6},  // R6 8-bit: no pair, reg 0x12 = 77
    {1'b0,1'b1,3'd0,16'h4020,16'h0000,4'd3},  // R3 full index, paired
    {1'b0,1'b1,3'd2,16'h9C3E,16'h0000,4'd6},  // R6 reg20=3E reg21=9C
    {1'b1,1'b1,3'd0,16'h0000,16'h4020,4'd3},  // R3 full index readback
    {1'b1,1'b1,3'd2,16'h0000,16'h003E,4'd6},  // R6 lower register
    {1'b0,1'b1,3'd0,16'h0021,16'h0000,4'd3},
    {1'b1,1'b1,3'd2,16'h0000,16'h009C,4'd6},  // R6 upper register
    {1'b0,1'b1,3'd0,16'h0013,16'h0000,4'd3},
    {1'b1,1'b1,3'd2,16'h0000,16'h0000,4'd6},  // R6 8-bit write did not pair
    {1'b0,1'b1,3'd0,16'h0012,16'h0000,4'd3},
    {1'b1,1'b1,3'd2,16'h0000,16'h0077,4'd4},  // R4 bit 14 masked
    {1'b0,1'b1,3'd1,16'h5555,16'h0000,4'd3},  // R3 window 1 ignored in 16-bit
    {1'b1,1'b1,3'd0,16'h0000,16'h0012,4'd3},  // R3 index unchanged
    {1'b1,1'b1,3'd1,16'h0000,16'h0000,4'd3},  // R3 window 1 reads zero
    {1'b0,1'b1,3'd5,16'h0033,16'h0000,4'd9},  // R9 upper window write dropped
    {1'b1,1'b1,3'd0,16'h0000,16'h0012,4'd9},  // R9 index unchanged
    {1'b1,1'b1,3'd6,16'h0000,16'h0000,4'd9},  // R9 upper window reads zero
    {1'b1,1'b1,3'd2,16'h0000,16'h0077,4'd9}   // R9 register unchanged
  };

  task automatic check(input logic [15:0] exp, input int req, input string what);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL R%0d %s: rdata=%h expected=%h", req, what, rdata, exp);
    end
  endtask

  task automatic wr(input logic m, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus16_mode = m; addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic m, input logic [2:0] a, input logic [15:0] exp,
                    input int req, input string what);
    @(negedge clk);
    bus16_mode = m; addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    check(exp, req, what);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(16'h0000, 1, "rdata after reset");          // R1
    rd(1'b1, 3'd0, 16'h0000, 1, "index after reset");  // R1
    rd(1'b1, 3'd2, 16'h0000, 1, "reg 0 after reset");  // R1

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][40]) rd(VEC[i][39], VEC[i][38:36], VEC[i][19:4], int'(VEC[i][3:0]), "table read");
      else            wr(VEC[i][39], VEC[i][38:36], VEC[i][35:20]);
    end

    // R6 pair starting on an odd register crosses banks
    wr(1'b1, 3'd0, 16'h4031); wr(1'b1, 3'd2, 16'h6655);
    wr(1'b1, 3'd0, 16'h0031); rd(1'b1, 3'd2, 16'h0055, 6, "odd pair low");
    wr(1'b1, 3'd0, 16'h0032); rd(1'b1, 3'd2, 16'h0066, 6, "odd pair high");

    // R7 out-of-range index: write dropped, no alias to reg 0
    wr(1'b1, 3'd0, 16'h0100); wr(1'b1, 3'd2, 16'h0011);
    rd(1'b1, 3'd2, 16'h0000, 7, "out-of-range read");
    wr(1'b1, 3'd0, 16'h0000); rd(1'b1, 3'd2, 16'h0000, 7, "reg 0 untouched");
    // R7 pair at last register: upper half dropped
    wr(1'b1, 3'd0, 16'h40FF); wr(1'b1, 3'd2, 16'hEE44);
    wr(1'b1, 3'd0, 16'h00FF); rd(1'b1, 3'd2, 16'h0044, 7, "last reg lower byte");
    wr(1'b1, 3'd0, 16'h0000); rd(1'b1, 3'd2, 16'h0000, 7, "no wrap to reg 0");

    // R5 hold across idle cycles
    wr(1'b1, 3'd0, 16'h0020); rd(1'b1, 3'd2, 16'h003E, 5, "read reg 0x20");
    repeat (4) @(negedge clk);
    check(16'h003E, 5, "rdata held while idle");

    // R8 deselected strobes do nothing
    @(negedge clk); addr = 3'd2; wdata = 16'h00C1; cs_n = 1'b1; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    check(16'h003E, 8, "deselected read ignored");
    rd(1'b1, 3'd2, 16'h003E, 8, "deselected write ignored");

    // R8 both strobes: write done, rdata unchanged
    @(negedge clk); addr = 3'd2; wdata = 16'h00D2; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    check(16'h003E, 8, "rdata kept on dual strobe");
    rd(1'b1, 3'd2, 16'h00D2, 8, "dual strobe wrote");

    // R1 reset clears stored registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(16'h0000, 1, "rdata after second reset");
    wr(1'b1, 3'd0, 16'h0020); rd(1'b1, 3'd2, 16'h0000, 1, "reg cleared by reset");

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end
endmodule